// File: doc/BRIEF.md
# 4:2:2 Parallel Video Output Formatter

This block sits at the end of a camera pixel pipeline. Each pixel arrives with an 8-bit luminance value and two 8-bit colour-difference values (R-Y and B-Y). The block decimates the colour-difference data to 4:2:2 and drives three outputs: a luma bus that carries a new sample for every pixel, a chroma bus that alternates between R-Y and B-Y, and a phase flag that shows which of the two is on the chroma bus.

Pixels are grouped into pairs. The even pixel of a pair supplies both colour-difference values. R-Y goes out with the even pixel and B-Y with the odd pixel. The odd pixel's own colour-difference inputs are discarded. A line-start strobe realigns the pairing, so the first pixel of every line starts a new pair. While the blanking input is high, the block replaces the pixel data with the video black level on luma and the zero-colour level on chroma.

The output register loads only when the input pixel strobe is high. An interface clock-enable output, delayed by one cycle, marks each cycle that carries a new output word.

Top module: `fmt422_top`

## Requirements
- R1: While reset is asserted and afterwards until the first accepted pixel, `y_out` is 16, `c_out` is 128, `c_phase` is 0 and `if_ce` is 0.
- R2: A pixel accepted (`pix_vld`=1) with `blank`=0 appears on `y_out` in the next cycle, with bit 7 as the MSB.
- R3: `if_ce` is 1 in exactly the cycles that follow a cycle with `pix_vld`=1. In a cycle after `pix_vld`=0, `if_ce` is 0 and `y_out`, `c_out` and `c_phase` keep their values.
- R4: `c_phase`=0 marks R-Y on `c_out` and `c_phase`=1 marks B-Y. Within a line, accepted pixels alternate between phase 0 (even) and phase 1 (odd), starting at 0.
- R5: An even pixel outputs its own `ry_in`. The following odd pixel outputs the `by_in` value sampled with that even pixel, even when idle cycles lie between the two pixels. The odd pixel's `ry_in` and `by_in` have no effect.
- R6: A pixel accepted with `line_start`=1 is an even pixel. A `line_start` pulse with `pix_vld`=0 makes the next accepted pixel even.
- R7: A pixel accepted with `blank`=1 produces `y_out`=16 and `c_out`=128. Its phase still follows R4 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld | input | 1 | Input pixel strobe |
| line_start | input | 1 | First-pixel-of-line strobe |
| blank | input | 1 | Blanking interval flag |
| y_in | input | 8 | Luminance sample |
| ry_in | input | 8 | R-Y sample |
| by_in | input | 8 | B-Y sample |
| y_out | output | 8 | Luma output bus |
| c_out | output | 8 | Multiplexed chroma output bus |
| c_phase | output | 1 | Chroma phase: 0 = R-Y, 1 = B-Y |
| if_ce | output | 1 | Interface clock enable for the output word |

## Verification
The assertions assume that the inputs are sampled only on clock edges, and that `line_start` and `blank` matter only together with `pix_vld`, except for the standalone line-start realignment. The bench changes inputs only on falling edges and keeps `pix_vld` low throughout reset. Every combination of `line_start`, `blank` and `pix_vld` that the checks depend on is given a defined level, so no property looks at an X value. Idle gaps are placed inside pixel pairs so that the stored B-Y value and the hold behaviour are both exercised.

// File: rtl/fmt422_pkg.sv
package fmt422_pkg;
  // Phase encoding of the chroma bus
  typedef enum logic {
    PH_RY = 1'b0,
    PH_BY = 1'b1
  } c_phase_e;
endpackage

// File: rtl/fmt422_phase.sv
module fmt422_phase
  import fmt422_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pix_vld,
  input  logic     line_start,
  output c_phase_e cur_phase
);
  c_phase_e nxt_q, nxt_d;

  // Phase of the pixel on the input this cycle
  always_comb begin
    cur_phase = line_start ? PH_RY : nxt_q;
  end

  always_comb begin
    nxt_d = nxt_q;
    if (pix_vld) begin
      nxt_d = (cur_phase == PH_RY) ? PH_BY : PH_RY;
    end else if (line_start) begin
      nxt_d = PH_RY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nxt_q <= PH_RY;
    else        nxt_q <= nxt_d;
  end
endmodule

// File: rtl/fmt422_chroma_sel.sv
module fmt422_chroma_sel
  import fmt422_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_vld,
  input  c_phase_e          cur_phase,
  input  logic [DATA_W-1:0] ry_in,
  input  logic [DATA_W-1:0] by_in,
  output logic [DATA_W-1:0] c_sel
);
  localparam logic [DATA_W-1:0] ZERO_C = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] by_hold_q, by_hold_d;
  logic              hold_en;

  always_comb begin
    hold_en   = pix_vld && (cur_phase == PH_RY);
    by_hold_d = hold_en ? by_in : by_hold_q;
    c_sel     = (cur_phase == PH_RY) ? ry_in : by_hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) by_hold_q <= ZERO_C;
    else        by_hold_q <= by_hold_d;
  end
endmodule

// File: rtl/fmt422_out_reg.sv
module fmt422_out_reg
  import fmt422_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_vld,
  input  logic              blank,
  input  c_phase_e          cur_phase,
  input  logic [DATA_W-1:0] y_in,
  input  logic [DATA_W-1:0] c_sel,
  output logic [DATA_W-1:0] y_out,
  output logic [DATA_W-1:0] c_out,
  output logic              c_phase,
  output logic              if_ce
);
  localparam int                SHIFT   = (DATA_W > 8) ? DATA_W - 8 : 0;
  localparam logic [DATA_W-1:0] BLACK_Y = DATA_W'(16) << SHIFT;
  localparam logic [DATA_W-1:0] ZERO_C  = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] y_d, c_d;
  logic              ph_d;

  always_comb begin
    y_d  = y_out;
    c_d  = c_out;
    ph_d = c_phase;
    if (pix_vld) begin
      y_d  = blank ? BLACK_Y : y_in;
      c_d  = blank ? ZERO_C  : c_sel;
      ph_d = cur_phase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_out   <= BLACK_Y;
      c_out   <= ZERO_C;
      c_phase <= 1'b0;
      if_ce   <= 1'b0;
    end else begin
      y_out   <= y_d;
      c_out   <= c_d;
      c_phase <= ph_d;
      if_ce   <= pix_vld;
    end
  end
endmodule

// File: rtl/fmt422_top.sv
module fmt422_top
  import fmt422_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_vld,
  input  logic              line_start,
  input  logic              blank,
  input  logic [DATA_W-1:0] y_in,
  input  logic [DATA_W-1:0] ry_in,
  input  logic [DATA_W-1:0] by_in,
  output logic [DATA_W-1:0] y_out,
  output logic [DATA_W-1:0] c_out,
  output logic              c_phase,
  output logic              if_ce
);
  c_phase_e          cur_phase;
  logic [DATA_W-1:0] c_sel;

  fmt422_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_vld   (pix_vld),
    .line_start(line_start),
    .cur_phase (cur_phase)
  );

  fmt422_chroma_sel #(.DATA_W(DATA_W)) u_csel (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_vld  (pix_vld),
    .cur_phase(cur_phase),
    .ry_in    (ry_in),
    .by_in    (by_in),
    .c_sel    (c_sel)
  );

  fmt422_out_reg #(.DATA_W(DATA_W)) u_oreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_vld  (pix_vld),
    .blank    (blank),
    .cur_phase(cur_phase),
    .y_in     (y_in),
    .c_sel    (c_sel),
    .y_out    (y_out),
    .c_out    (c_out),
    .c_phase  (c_phase),
    .if_ce    (if_ce)
  );
endmodule

// File: rtl/fmt422_checker.sv
module fmt422_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_vld,
  input logic              line_start,
  input logic              blank,
  input logic [DATA_W-1:0] y_in,
  input logic [DATA_W-1:0] ry_in,
  input logic [DATA_W-1:0] y_out,
  input logic [DATA_W-1:0] c_out,
  input logic              c_phase,
  input logic              if_ce
);
  localparam int                SHIFT   = (DATA_W > 8) ? DATA_W - 8 : 0;
  localparam logic [DATA_W-1:0] BLACK_Y = DATA_W'(16) << SHIFT;
  localparam logic [DATA_W-1:0] ZERO_C  = DATA_W'(1) << (DATA_W - 1);

  p_reset_vals_r1: assert property (@(posedge clk)
    !rst_n |=> (!rst_n ? (y_out == BLACK_Y && c_out == ZERO_C && !if_ce) : 1'b1));

  p_luma_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && !blank) |=> (y_out == $past(y_in)));

  p_ce_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |=> if_ce);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |=> (!if_ce && $stable(y_out) && $stable(c_out) && $stable(c_phase)));

  p_line_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && line_start) |=> (c_phase == 1'b0));

  p_even_ry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && line_start && !blank) |=> (c_out == $past(ry_in)));

  p_blank_lvls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && blank) |=> (y_out == BLACK_Y && c_out == ZERO_C));
endmodule

bind fmt422_top fmt422_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_vld   (pix_vld),
  .line_start(line_start),
  .blank     (blank),
  .y_in      (y_in),
  .ry_in     (ry_in),
  .y_out     (y_out),
  .c_out     (c_out),
  .c_phase   (c_phase),
  .if_ce     (if_ce)
);

// File: tb/fmt422_top_tb_top.sv
module fmt422_top_tb_top;
  typedef struct packed {
    logic       ls;
    logic       blk;
    logic [7:0] y;
    logic [7:0] ry;
    logic [7:0] by;
    logic [7:0] ey;
    logic [7:0] ec;
    logic       eph;
  } vec_t;

  localparam int NV = 9;
  // Odd pixels carry their own R-Y/B-Y values, which must be dropped (R5)
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 8'd10,  8'd20,  8'd30,  8'd10,  8'd20,  1'b0},
    '{1'b0, 1'b0, 8'd11,  8'd21,  8'd31,  8'd11,  8'd30,  1'b1},
    '{1'b0, 1'b0, 8'd200, 8'd40,  8'd50,  8'd200, 8'd40,  1'b0},
    '{1'b0, 1'b0, 8'd201, 8'd41,  8'd51,  8'd201, 8'd50,  1'b1},
    '{1'b1, 1'b0, 8'd5,   8'd60,  8'd70,  8'd5,   8'd60,  1'b0},
    '{1'b1, 1'b0, 8'd6,   8'd61,  8'd71,  8'd6,   8'd61,  1'b0},
    '{1'b0, 1'b1, 8'd99,  8'd1,   8'd2,   8'd16,  8'd128, 1'b1},
    '{1'b0, 1'b0, 8'd235, 8'd240, 8'd250, 8'd235, 8'd240, 1'b0},
    '{1'b0, 1'b0, 8'd0,   8'd255, 8'd3,   8'd0,   8'd250, 1'b1}
  };

  logic       clk, rst_n, pix_vld, line_start, blank;
  logic [7:0] y_in, ry_in, by_in, y_out, c_out;
  logic       c_phase, if_ce;
  int         n_chk, n_err;
  logic       done;

  fmt422_top dut_i (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .line_start(line_start),
    .blank(blank), .y_in(y_in), .ry_in(ry_in), .by_in(by_in),
    .y_out(y_out), .c_out(c_out), .c_phase(c_phase), .if_ce(if_ce)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, return at the next falling edge
  task automatic drive(input logic v, input logic ls, input logic b,
                       input logic [7:0] y, input logic [7:0] r, input logic [7:0] bb);
    pix_vld = v; line_start = ls; blank = b; y_in = y; ry_in = r; by_in = bb;
    @(negedge clk);
  endtask

  task automatic chk_out(input string tag, input int ey, input int ec,
                         input int eph, input int ece);
    chk({tag, " y_out"},   y_out,   ey);
    chk({tag, " c_out"},   c_out,   ec);
    chk({tag, " c_phase"}, c_phase, eph);
    chk({tag, " if_ce"},   if_ce,   ece);
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0;
    pix_vld = 1'b0; line_start = 1'b0; blank = 1'b0;
    y_in = '0; ry_in = '0; by_in = '0;
    repeat (3) @(negedge clk);
    chk_out("R1 in reset", 16, 128, 0, 0);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 8'd77, 8'd77, 8'd77);
    chk_out("R1 after release", 16, 128, 0, 0);

    // Table walk: R2 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, TBL[i].ls, TBL[i].blk, TBL[i].y, TBL[i].ry, TBL[i].by);
      chk_out($sformatf("R2/R4/R5/R6/R7 vec%0d", i),
              TBL[i].ey, TBL[i].ec, TBL[i].eph, 1);
    end

    // R3: idle cycle holds the outputs, ce low
    drive(1'b0, 1'b0, 1'b0, 8'd9, 8'd9, 8'd9);
    chk_out("R3 idle hold", 0, 250, 1, 0);

    // R5: even pixel, idle gap, odd pixel gets the held B-Y
    drive(1'b1, 1'b0, 1'b0, 8'd33, 8'd44, 8'd55);
    chk_out("R5 even", 33, 44, 0, 1);
    drive(1'b0, 1'b0, 1'b0, 8'd1, 8'd1, 8'd1);
    chk_out("R3 gap", 33, 44, 0, 0);
    drive(1'b1, 1'b0, 1'b0, 8'd34, 8'd99, 8'd98);
    chk_out("R5 odd after gap", 34, 55, 1, 1);

    // R6: standalone line_start realigns the next pixel to even
    drive(1'b1, 1'b0, 1'b0, 8'd50, 8'd51, 8'd52);
    chk_out("R6 even before", 50, 51, 0, 1);
    drive(1'b0, 1'b1, 1'b0, 8'd0, 8'd0, 8'd0);
    chk_out("R6 strobe alone", 50, 51, 0, 0);
    drive(1'b1, 1'b0, 1'b0, 8'd60, 8'd61, 8'd62);
    chk_out("R6 even after strobe", 60, 61, 0, 1);
    drive(1'b1, 1'b0, 1'b0, 8'd63, 8'd64, 8'd65);
    chk_out("R6 odd after strobe", 63, 62, 1, 1);

    // R7: blank on even pixel, then unblanked odd pixel
    drive(1'b1, 1'b0, 1'b1, 8'd200, 8'd201, 8'd202);
    chk_out("R7 blank even", 16, 128, 0, 1);
    drive(1'b1, 1'b0, 1'b0, 8'd203, 8'd204, 8'd205);
    chk_out("R7 odd after blank", 203, 202, 1, 1);

    // R1: reset again mid-stream
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 8'd0);
    chk_out("R1 re-reset", 16, 128, 0, 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule